// File: doc/BRIEF.md
# Drive Interface Interrupt Controller

This block collects interrupt events for the host side of an optical-drive interface and drives one interrupt line for the host. It holds a 32-bit request word and a 32-bit enable mask. Seven request bits are implemented, in the top part of the word. The rest read as zero. Outside this block, the engines raise events with one-cycle set pulses: command DMA, response DMA, sector DMA sequencer, byte-wide PIO port and subcode capture.

The host does not clear a request by writing to the request word. Each bit is cleared by a pulse that comes from one particular register access elsewhere in the interface. The host bus decoder turns those accesses into strobes. The port transfer mode also qualifies events. While the interface works by PIO, the two DMA completion events are discarded. While it works by DMA, the two PIO handshake events are discarded.

The enable mask is a plain 32-bit register that the host can read and write. The interrupt line is registered. It is high in the cycle after the masked request word becomes nonzero.

Top module: `drive_irq_ctrl`

## Requirements
- R1: After reset, the request word, the enable mask and the interrupt line are all zero.
- R2: A pulse on the subcode, sector-DMA or overflow event sets request bit 31, 26 or 25 respectively, in either transfer mode.
- R3: Pulses on the command-done and status-pending events set bits 30 and 29 only while `pio_mode` is 1. While `pio_mode` is 0 they leave the request word unchanged.
- R4: Pulses on the transmit-DMA and receive-DMA completion events set bits 28 and 27 only while `pio_mode` is 0. While `pio_mode` is 1 they leave the request word unchanged.
- R5: A PIO write strobe clears bit 30. A PIO read strobe clears bit 29 only when `rsp_data_left` is 0. With `rsp_data_left` at 1, bit 29 stays set.
- R6: A transmit end-position write clears bit 28. A receive end-position write clears bit 27. Any block-enable write clears bit 26.
- R7: The subcode acknowledge strobe clears bit 31. The overflow acknowledge strobe clears bit 25.
- R8: When a set pulse and a clear strobe reach the same bit in the same cycle, the bit ends up set.
- R9: A mask write loads all 32 bits of `mask_wdata`. `mask_rdata` returns the stored mask from the next cycle on.
- R10: `irq_out` equals the OR over (request AND mask) as it stood one cycle earlier. A request whose mask bit is 0 does not raise it.
- R11: Request bits 24 down to 0 always read as zero.
- R12: Each clear strobe changes only its own request bit. The other set bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_mode | input | 1 | 1 = byte-wise PIO transfer mode, 0 = DMA transfer mode |
| ev_subcode | input | 1 | Subcode buffer filled (sets bit 31) |
| ev_cmd_done | input | 1 | Command received and executed, PIO (sets bit 30) |
| ev_stat_pend | input | 1 | Status data pending, PIO (sets bit 29) |
| ev_tx_dma_done | input | 1 | Command transmit DMA finished (sets bit 28) |
| ev_rx_dma_done | input | 1 | Status receive DMA finished (sets bit 27) |
| ev_sect_dma_done | input | 1 | Sector data DMA finished (sets bit 26) |
| ev_dma_ovf | input | 1 | DMA overflow, data lost (sets bit 25) |
| acc_pio_wr | input | 1 | PIO byte written (clears bit 30) |
| acc_pio_rd | input | 1 | PIO byte read (may clear bit 29) |
| rsp_data_left | input | 1 | Response bytes remain after this read |
| acc_tx_end_wr | input | 1 | Transmit end position written (clears bit 28) |
| acc_rx_end_wr | input | 1 | Receive end position written (clears bit 27) |
| acc_blk_en_wr | input | 1 | Block-enable register written (clears bit 26) |
| acc_subcode_ack | input | 1 | Subcode acknowledge (clears bit 31) |
| acc_ovf_ack | input | 1 | Overflow acknowledge (clears bit 25) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | Mask write data |
| mask_rdata | output | 32 | Current enable mask |
| req_rdata | output | 32 | Current request word |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that every event and access input is a one-cycle strobe that the decoder produces synchronously to `clk`. They also assume that `pio_mode` is a level that the properties may sample on the same edge as the strobes. The properties about gating by mode check only that a bit stays clear while it is clear and the wrong mode is selected. They make no claim about what the decoder drives. The bench changes `pio_mode` only at falling edges and only between scenarios. It gives every strobe exactly one cycle. Where it wants a set and a clear on the same bit together, it raises them in the same cycle on purpose.

// File: rtl/drive_irq_pkg.sv
package drive_irq_pkg;

  // Number of implemented request sources and the bit position of the lowest.
  localparam int NSRC   = 7;
  localparam int LO_BIT = 25;

  // Index of each source inside the NSRC-wide internal vectors.
  // Word bit position = LO_BIT + index.
  localparam int S_OVF  = 0;  // bit 25
  localparam int S_SECT = 1;  // bit 26
  localparam int S_RXD  = 2;  // bit 27
  localparam int S_TXD  = 3;  // bit 28
  localparam int S_STAT = 4;  // bit 29
  localparam int S_CMD  = 5;  // bit 30
  localparam int S_SUBC = 6;  // bit 31

  localparam logic [NSRC-1:0] PIO_ONLY = (NSRC'(1) << S_CMD) | (NSRC'(1) << S_STAT);
  localparam logic [NSRC-1:0] DMA_ONLY = (NSRC'(1) << S_TXD) | (NSRC'(1) << S_RXD);

  typedef enum logic { XFER_DMA = 1'b0, XFER_PIO = 1'b1 } xfer_mode_e;

  // Drop events that do not belong to the selected transfer mode.
  function automatic logic [NSRC-1:0] gate_by_mode(input logic [NSRC-1:0] raw,
                                                   input xfer_mode_e mode);
    logic [NSRC-1:0] blocked;
    blocked = (mode == XFER_PIO) ? DMA_ONLY : PIO_ONLY;
    return raw & ~blocked;
  endfunction

  // Next state of one request bit; a set beats a clear in the same cycle.
  function automatic logic req_next(input logic q, input logic s, input logic c);
    return s | (q & ~c);
  endfunction

  // Reduce the enabled requests to one interrupt level.
  function automatic logic any_enabled(input logic [31:0] req, input logic [31:0] msk);
    return |(req & msk);
  endfunction

endpackage

// File: rtl/drive_irq_set_gate.sv
module drive_irq_set_gate
  import drive_irq_pkg::*;
(
  input  logic            pio_mode,
  input  logic            ev_subcode,
  input  logic            ev_cmd_done,
  input  logic            ev_stat_pend,
  input  logic            ev_tx_dma_done,
  input  logic            ev_rx_dma_done,
  input  logic            ev_sect_dma_done,
  input  logic            ev_dma_ovf,
  output logic [NSRC-1:0] set_v
);
  logic [NSRC-1:0] raw;
  xfer_mode_e      mode;

  always_comb begin
    raw         = '0;
    raw[S_SUBC] = ev_subcode;
    raw[S_CMD]  = ev_cmd_done;
    raw[S_STAT] = ev_stat_pend;
    raw[S_TXD]  = ev_tx_dma_done;
    raw[S_RXD]  = ev_rx_dma_done;
    raw[S_SECT] = ev_sect_dma_done;
    raw[S_OVF]  = ev_dma_ovf;
  end

  assign mode  = pio_mode ? XFER_PIO : XFER_DMA;
  assign set_v = gate_by_mode(raw, mode);
endmodule

// File: rtl/drive_irq_clr_decode.sv
module drive_irq_clr_decode
  import drive_irq_pkg::*;
(
  input  logic            acc_pio_wr,
  input  logic            acc_pio_rd,
  input  logic            rsp_data_left,
  input  logic            acc_tx_end_wr,
  input  logic            acc_rx_end_wr,
  input  logic            acc_blk_en_wr,
  input  logic            acc_subcode_ack,
  input  logic            acc_ovf_ack,
  output logic [NSRC-1:0] clr_v
);
  // The status-pending bit drops only once the last response byte is taken.
  logic rd_drained;
  assign rd_drained = acc_pio_rd & ~rsp_data_left;

  always_comb begin
    clr_v         = '0;
    clr_v[S_SUBC] = acc_subcode_ack;
    clr_v[S_CMD]  = acc_pio_wr;
    clr_v[S_STAT] = rd_drained;
    clr_v[S_TXD]  = acc_tx_end_wr;
    clr_v[S_RXD]  = acc_rx_end_wr;
    clr_v[S_SECT] = acc_blk_en_wr;
    clr_v[S_OVF]  = acc_ovf_ack;
  end
endmodule

// File: rtl/drive_irq_req_reg.sv
module drive_irq_req_reg
  import drive_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_v,
  input  logic [NSRC-1:0] clr_v,
  output logic [W-1:0]    req_q
);
  localparam int HI_BIT = LO_BIT + NSRC - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= LO_BIT && i <= HI_BIT) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= req_next(q, set_v[i-LO_BIT], clr_v[i-LO_BIT]);
      end
      assign req_q[i] = q;
    end else begin : g_tie
      assign req_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/drive_irq_out.sv
module drive_irq_out
  import drive_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] req_q,
  output logic [W-1:0] mask_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_enabled(req_q, mask_q);
  end
endmodule

// File: rtl/drive_irq_ctrl.sv
module drive_irq_ctrl
  import drive_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pio_mode,
  input  logic        ev_subcode,
  input  logic        ev_cmd_done,
  input  logic        ev_stat_pend,
  input  logic        ev_tx_dma_done,
  input  logic        ev_rx_dma_done,
  input  logic        ev_sect_dma_done,
  input  logic        ev_dma_ovf,
  input  logic        acc_pio_wr,
  input  logic        acc_pio_rd,
  input  logic        rsp_data_left,
  input  logic        acc_tx_end_wr,
  input  logic        acc_rx_end_wr,
  input  logic        acc_blk_en_wr,
  input  logic        acc_subcode_ack,
  input  logic        acc_ovf_ack,
  input  logic        mask_wr,
  input  logic [31:0] mask_wdata,
  output logic [31:0] mask_rdata,
  output logic [31:0] req_rdata,
  output logic        irq_out
);
  localparam int W = 32;

  // Named internal events, visible to the bound checker.
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [W-1:0]    req_q;
  logic [W-1:0]    mask_q;
  logic            irq_q;

  drive_irq_set_gate u_set (
    .pio_mode         (pio_mode),
    .ev_subcode       (ev_subcode),
    .ev_cmd_done      (ev_cmd_done),
    .ev_stat_pend     (ev_stat_pend),
    .ev_tx_dma_done   (ev_tx_dma_done),
    .ev_rx_dma_done   (ev_rx_dma_done),
    .ev_sect_dma_done (ev_sect_dma_done),
    .ev_dma_ovf       (ev_dma_ovf),
    .set_v            (set_v)
  );

  drive_irq_clr_decode u_clr (
    .acc_pio_wr      (acc_pio_wr),
    .acc_pio_rd      (acc_pio_rd),
    .rsp_data_left   (rsp_data_left),
    .acc_tx_end_wr   (acc_tx_end_wr),
    .acc_rx_end_wr   (acc_rx_end_wr),
    .acc_blk_en_wr   (acc_blk_en_wr),
    .acc_subcode_ack (acc_subcode_ack),
    .acc_ovf_ack     (acc_ovf_ack),
    .clr_v           (clr_v)
  );

  drive_irq_req_reg #(.W(W)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (set_v),
    .clr_v (clr_v),
    .req_q (req_q)
  );

  drive_irq_out #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .req_q      (req_q),
    .mask_q     (mask_q),
    .irq_q      (irq_q)
  );

  assign req_rdata  = req_q;
  assign mask_rdata = mask_q;
  assign irq_out    = irq_q;
endmodule

// File: rtl/drive_irq_ctrl_chk.sv
module drive_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pio_mode,
  input logic        ev_sect_dma_done,
  input logic        ev_subcode,
  input logic        acc_blk_en_wr,
  input logic        acc_pio_rd,
  input logic        rsp_data_left,
  input logic        mask_wr,
  input logic [31:0] mask_wdata,
  input logic [31:0] req_rdata,
  input logic [31:0] mask_rdata,
  input logic        irq_out
);
  // R11
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_rdata[24:0] == 25'd0);

  // R3
  pio_bits_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pio_mode && req_rdata[30:29] == 2'b00) |=> req_rdata[30:29] == 2'b00);

  // R4
  dma_bits_pio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pio_mode && req_rdata[28:27] == 2'b00) |=> req_rdata[28:27] == 2'b00);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sect_dma_done |=> req_rdata[26]);

  // R2
  subcode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_subcode |=> req_rdata[31]);

  // R6
  blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_blk_en_wr && !ev_sect_dma_done) |=> !req_rdata[26]);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pio_rd && rsp_data_left && req_rdata[29]) |=> req_rdata[29]);

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_rdata == $past(mask_wdata));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_rdata & mask_rdata)) |=> irq_out);

  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_rdata & mask_rdata)) |=> !irq_out);
endmodule

bind drive_irq_ctrl drive_irq_ctrl_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .pio_mode         (pio_mode),
  .ev_sect_dma_done (ev_sect_dma_done),
  .ev_subcode       (ev_subcode),
  .acc_blk_en_wr    (acc_blk_en_wr),
  .acc_pio_rd       (acc_pio_rd),
  .rsp_data_left    (rsp_data_left),
  .mask_wr          (mask_wr),
  .mask_wdata       (mask_wdata),
  .req_rdata        (req_rdata),
  .mask_rdata       (mask_rdata),
  .irq_out          (irq_out)
);

// File: tb/drive_irq_ctrl_tb.sv
module drive_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pio_mode = 1'b0;
  logic        ev_subcode = 0, ev_cmd_done = 0, ev_stat_pend = 0, ev_tx_dma_done = 0;
  logic        ev_rx_dma_done = 0, ev_sect_dma_done = 0, ev_dma_ovf = 0;
  logic        acc_pio_wr = 0, acc_pio_rd = 0, rsp_data_left = 0;
  logic        acc_tx_end_wr = 0, acc_rx_end_wr = 0, acc_blk_en_wr = 0;
  logic        acc_subcode_ack = 0, acc_ovf_ack = 0;
  logic        mask_wr = 0;
  logic [31:0] mask_wdata = '0;
  logic [31:0] mask_rdata, req_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  drive_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pio_mode(pio_mode),
    .ev_subcode(ev_subcode), .ev_cmd_done(ev_cmd_done), .ev_stat_pend(ev_stat_pend),
    .ev_tx_dma_done(ev_tx_dma_done), .ev_rx_dma_done(ev_rx_dma_done),
    .ev_sect_dma_done(ev_sect_dma_done), .ev_dma_ovf(ev_dma_ovf),
    .acc_pio_wr(acc_pio_wr), .acc_pio_rd(acc_pio_rd), .rsp_data_left(rsp_data_left),
    .acc_tx_end_wr(acc_tx_end_wr), .acc_rx_end_wr(acc_rx_end_wr),
    .acc_blk_en_wr(acc_blk_en_wr), .acc_subcode_ack(acc_subcode_ack),
    .acc_ovf_ack(acc_ovf_ack), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .mask_rdata(mask_rdata), .req_rdata(req_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic release_all();
    {ev_subcode, ev_cmd_done, ev_stat_pend, ev_tx_dma_done, ev_rx_dma_done,
     ev_sect_dma_done, ev_dma_ovf} = '0;
    {acc_pio_wr, acc_pio_rd, acc_tx_end_wr, acc_rx_end_wr, acc_blk_en_wr,
     acc_subcode_ack, acc_ovf_ack, mask_wr} = '0;
  endtask

  // Strobes are raised by the caller at a falling edge; this holds them for
  // one rising edge, drops them and returns at the next falling edge.
  task automatic one_cycle();
    @(negedge clk);
    release_all();
  endtask

  task automatic t_reset();
    check("R1 req", req_rdata, 32'h0);
    check("R1 mask", mask_rdata, 32'h0);
    check("R1 irq", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_mask();
    mask_wr = 1; mask_wdata = 32'hA5C3_0F18; one_cycle();
    check("R9 mask readback", mask_rdata, 32'hA5C3_0F18);
    mask_wdata = 32'h0; @(negedge clk);
    check("R9 mask held", mask_rdata, 32'hA5C3_0F18);
    mask_wr = 1; mask_wdata = 32'h0; one_cycle();
    check("R9 mask zero", mask_rdata, 32'h0);
  endtask

  task automatic t_any_mode();
    pio_mode = 0;
    ev_subcode = 1; ev_sect_dma_done = 1; ev_dma_ovf = 1; one_cycle();
    check("R2 set in DMA mode", req_rdata, 32'h8600_0000);
    check("R11 low bits zero", req_rdata & 32'h01FF_FFFF, 32'h0);
    acc_subcode_ack = 1; one_cycle();
    check("R7/R12 subcode ack", req_rdata, 32'h0600_0000);
    acc_blk_en_wr = 1; one_cycle();
    check("R6/R12 block enable write", req_rdata, 32'h0200_0000);
    acc_ovf_ack = 1; one_cycle();
    check("R7 overflow ack", req_rdata, 32'h0);
    pio_mode = 1;
    ev_subcode = 1; ev_dma_ovf = 1; one_cycle();
    check("R2 set in PIO mode", req_rdata, 32'h8200_0000);
    acc_subcode_ack = 1; acc_ovf_ack = 1; one_cycle();
    check("R7 both acks", req_rdata, 32'h0);
  endtask

  task automatic t_dma_mode();
    pio_mode = 0;
    ev_cmd_done = 1; ev_stat_pend = 1; one_cycle();
    check("R3 PIO events ignored in DMA", req_rdata, 32'h0);
    ev_tx_dma_done = 1; ev_rx_dma_done = 1; one_cycle();
    check("R4 DMA events in DMA", req_rdata, 32'h1800_0000);
    acc_tx_end_wr = 1; one_cycle();
    check("R6 tx end write", req_rdata, 32'h0800_0000);
    acc_rx_end_wr = 1; one_cycle();
    check("R6 rx end write", req_rdata, 32'h0);
  endtask

  task automatic t_pio_mode();
    pio_mode = 1;
    ev_tx_dma_done = 1; ev_rx_dma_done = 1; one_cycle();
    check("R4 DMA events ignored in PIO", req_rdata, 32'h0);
    ev_cmd_done = 1; ev_stat_pend = 1; one_cycle();
    check("R3 PIO events in PIO", req_rdata, 32'h6000_0000);
    acc_pio_rd = 1; rsp_data_left = 1; one_cycle();
    check("R5 read with data left", req_rdata, 32'h6000_0000);
    acc_pio_rd = 1; rsp_data_left = 0; one_cycle();
    check("R5 read drains", req_rdata, 32'h4000_0000);
    acc_pio_wr = 1; one_cycle();
    check("R5 pio write", req_rdata, 32'h0);
  endtask

  task automatic t_set_wins();
    pio_mode = 0;
    ev_sect_dma_done = 1; acc_blk_en_wr = 1; one_cycle();
    check("R8 set beats clear bit26", req_rdata, 32'h0400_0000);
    ev_tx_dma_done = 1; acc_tx_end_wr = 1; one_cycle();
    check("R8 set beats clear bit28", req_rdata, 32'h1400_0000);
    acc_blk_en_wr = 1; acc_tx_end_wr = 1; one_cycle();
    check("R8 cleanup", req_rdata, 32'h0);
  endtask

  task automatic t_irq();
    pio_mode = 0;
    mask_wr = 1; mask_wdata = 32'h0400_0000; one_cycle();
    ev_dma_ovf = 1; one_cycle();
    @(negedge clk);
    check("R10 masked request stays quiet", {31'd0, irq_out}, 32'h0);
    ev_sect_dma_done = 1; one_cycle();
    check("R10 irq registered, not yet high", {31'd0, irq_out}, 32'h0);
    @(negedge clk);
    check("R10 irq high", {31'd0, irq_out}, 32'h1);
    acc_blk_en_wr = 1; one_cycle();
    check("R10 irq still high after clear", {31'd0, irq_out}, 32'h1);
    @(negedge clk);
    check("R10 irq drops", {31'd0, irq_out}, 32'h0);
    acc_ovf_ack = 1; mask_wr = 1; mask_wdata = 32'h0; one_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_any_mode();
    t_dma_mode();
    t_pio_mode();
    t_set_wins();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule